// File: doc/BRIEF.md
# Two-Channel Flit Reassembler for Network Egress

This block sits between a router's output port and a user module. Flits reach it on two virtual channels. Flits of packets on different channels may arrive interleaved, one flit per cycle at most. Each channel has its own flit store. A credit-return pulse goes back to the router for every flit taken out of a store, so the router never sends more flits than a store can hold.

An assembler takes one channel at a time and only starts at a packet boundary. It collects that packet's flits, up to four of them, into one wide word and presents the word over valid/ready. It never mixes flits of two packets into one word in normal operation. Channel 1 wins when both channels have data waiting.

A combine mode joins one packet from each channel into a single word:
- the channel-1 packet fills the upper half;
- the channel-2 packet fills the lower half.

Top module: `vc_egress_reassembler`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `out_data` is all zero and `credit_ret` is 0.
- R2: Flits are stored per channel (`in_vc`=0 is channel 1, `in_vc`=1 is channel 2). Each output word holds the flits of exactly one packet, in arrival order, even when flits of packets on the two channels arrive interleaved.
- R3: In normal mode, flit k (counting from 0) of a packet lands at bits [k*FLIT_W +: FLIT_W] of `out_data`, and unused slots are zero. `out_valid` rises only after the flit with `in_tail`=1 has been collected.
- R4: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R5: When the assembler is idle and both channels hold flits, the next word is taken from channel 1.
- R6: Once a packet has been started on a channel, no flit of the other channel is taken until that packet's tail flit has been taken.
- R7: `credit_ret[v]` pulses for one cycle, the cycle after each flit removed from channel v's store. The number of pulses equals the number of flits received on that channel.
- R8: With `combine_mode`=1, no word is produced until both channels hold a complete packet. Each packet must then be at most SLOTS/2 flits. Channel-1 flit k goes to slot SLOTS/2+k, channel-2 flit k goes to slot k, and unused slots are zero.
- R9: A channel's store never holds more than BUF_DEPTH flits when the sender respects credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| combine_mode | input | 1 | 1 = join one packet from each channel per word; sampled when idle |
| in_valid | input | 1 | Flit present this cycle |
| in_vc | input | 1 | Channel of the flit (0 = channel 1, 1 = channel 2) |
| in_tail | input | 1 | Flit is the last of its packet |
| in_data | input | FLIT_W | Flit payload |
| credit_ret | output | 2 | Per-channel credit pulse, bit 0 for channel 1 |
| out_valid | output | 1 | Assembled word available |
| out_ready | input | 1 | User module accepts the word |
| out_data | output | SLOTS*FLIT_W | Assembled word |

## Verification
The bench targets the following corner cases, with the failure each one exposes:
- Interleaved arrival. A design that assembles by arrival time instead of by channel would mix flits of two packets into one word.
- Late channel-1 packet while a channel-2 packet is half collected. A design that preempts at that point would deliver the channel-1 packet first or splice it into the channel-2 word.
- Both channels waiting while the output is stalled. A wrong arbiter would emit the channel-2 word first.
- Stalled output. A design that lets the word change before acceptance would show a different word on a second sample.
- Combine mode. A design that starts early would raise valid with only the channel-1 half filled; one that swaps halves would put channel-2 data on top.
- Random traffic with random stalls. A design that loses or double-counts credit pulses would end with the bench's credit tally unbalanced.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NUM_VC = 2;

  typedef enum logic [1:0] {
    AS_IDLE    = 2'd0,
    AS_COLLECT = 2'd1,
    AS_HOLD    = 2'd2
  } asm_state_t;
endpackage

// File: rtl/vcr_flit_buffer.sv
module vcr_flit_buffer #(
  parameter int W     = 150,
  parameter int DEPTH = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         push_tail,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head_data,
  output logic                         head_tail,
  output logic                         nonempty,
  output logic                         pkt_avail,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] pkt_cnt;
  logic          pop_tail;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_tail, push_data};
  end

  assign head_data = mem[rd_ptr][W-1:0];
  assign head_tail = mem[rd_ptr][W];
  assign nonempty  = (count != '0);
  assign pkt_avail = (pkt_cnt != '0);
  assign pop_tail  = pop && head_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      pkt_cnt <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count   <= count + CW'(push) - CW'(pop);
      pkt_cnt <= pkt_cnt + CW'(push && push_tail) - CW'(pop_tail);
    end
  end
endmodule

// File: rtl/vcr_assembler.sv
module vcr_assembler
  import vcr_pkg::*;
#(
  parameter int W     = 150,
  parameter int SLOTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        combine_mode,
  input  logic [NUM_VC-1:0]           nonempty,
  input  logic [NUM_VC-1:0]           pkt_avail,
  input  logic [NUM_VC-1:0][W-1:0]    head_data,
  input  logic [NUM_VC-1:0]           head_tail,
  output logic [NUM_VC-1:0]           pop,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [SLOTS*W-1:0]          out_data
);
  localparam int HALF = SLOTS / 2;
  localparam int SW   = $clog2(SLOTS+1);

  asm_state_t    state;
  logic          sel_q, comb_q;
  logic [SW-1:0] slot_q;

  logic          idle, comb_eff, pick, pop_en, hd_tail;
  logic [SW-1:0] base, limit;
  logic [W-1:0]  hd;

  always_comb begin
    idle = (state == AS_IDLE);
    if (idle) begin
      comb_eff = combine_mode;
      if (combine_mode) begin
        pop_en = pkt_avail[0] && pkt_avail[1];
        pick   = 1'b0;
        base   = SW'(HALF);
      end else begin
        pop_en = |nonempty;
        pick   = !nonempty[0];
        base   = '0;
      end
    end else begin
      comb_eff = comb_q;
      pick     = sel_q;
      base     = slot_q;
      pop_en   = (state == AS_COLLECT) && nonempty[sel_q];
    end
    hd      = head_data[pick];
    hd_tail = head_tail[pick];
    limit   = (comb_eff && pick) ? SW'(HALF) : SW'(SLOTS);
    pop     = pop_en ? (NUM_VC'(1) << pick) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= AS_IDLE;
      sel_q     <= 1'b0;
      comb_q    <= 1'b0;
      slot_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_data  <= '0;
        state     <= AS_IDLE;
      end
      if (pop_en) begin
        for (int k = 0; k < SLOTS; k++) begin
          if (base == SW'(k) && base < limit) out_data[k*W +: W] <= hd;
        end
        comb_q <= comb_eff;
        if (hd_tail) begin
          if (comb_eff && !pick) begin
            sel_q  <= 1'b1;
            slot_q <= '0;
            state  <= AS_COLLECT;
          end else begin
            state     <= AS_HOLD;
            out_valid <= 1'b1;
          end
        end else begin
          state  <= AS_COLLECT;
          sel_q  <= pick;
          slot_q <= (base == SW'(SLOTS)) ? base : base + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vc_egress_reassembler.sv
module vc_egress_reassembler
  import vcr_pkg::*;
#(
  parameter int FLIT_W     = 150,
  parameter int SLOTS      = 4,
  parameter int BUF_DEPTH  = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      combine_mode,
  input  logic                      in_valid,
  input  logic                      in_vc,
  input  logic                      in_tail,
  input  logic [FLIT_W-1:0]         in_data,
  output logic [1:0]                credit_ret,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [SLOTS*FLIT_W-1:0]   out_data
);
  localparam int CNT_W = $clog2(BUF_DEPTH+1);

  logic [NUM_VC-1:0]              vc_nonempty, vc_pkt, vc_head_tail, vc_pop;
  logic [NUM_VC-1:0][FLIT_W-1:0]  vc_head;
  logic [NUM_VC-1:0][CNT_W-1:0]   vc_count;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vcr_flit_buffer #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .push      (in_valid && (in_vc == 1'(v))),
      .push_tail (in_tail),
      .push_data (in_data),
      .pop       (vc_pop[v]),
      .head_data (vc_head[v]),
      .head_tail (vc_head_tail[v]),
      .nonempty  (vc_nonempty[v]),
      .pkt_avail (vc_pkt[v]),
      .count     (vc_count[v])
    );

    always_ff @(posedge clk) begin
      if (rst) credit_ret[v] <= 1'b0;
      else     credit_ret[v] <= vc_pop[v];
    end
  end

  vcr_assembler #(.W(FLIT_W), .SLOTS(SLOTS)) u_asm (
    .clk          (clk),
    .rst          (rst),
    .combine_mode (combine_mode),
    .nonempty     (vc_nonempty),
    .pkt_avail    (vc_pkt),
    .head_data    (vc_head),
    .head_tail    (vc_head_tail),
    .pop          (vc_pop),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data)
  );
endmodule

// File: rtl/vcr_reassembler_chk.sv
module vcr_reassembler_chk #(
  parameter int OW    = 600,
  parameter int CW    = 4,
  parameter int DEPTH = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 combine_mode,
  input logic                 in_valid,
  input logic                 in_vc,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [OW-1:0]        out_data,
  input logic [1:0]           credit_ret,
  input logic [1:0]           vc_pop,
  input logic [1:0]           vc_head_tail,
  input logic [1:0][CW-1:0]   vc_count
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_tail_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past((vc_pop[0] && vc_head_tail[0]) || (vc_pop[1] && vc_head_tail[1])));

  assert_no_switch_vc1_R6: assert property (@(posedge clk) disable iff (rst)
    (vc_pop[0] && !vc_head_tail[0]) |=> !vc_pop[1]);

  assert_no_switch_vc2_R6: assert property (@(posedge clk) disable iff (rst)
    (vc_pop[1] && !vc_head_tail[1]) |=> !vc_pop[0]);

  assert_one_pop_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vc_pop));

  assert_credit_vc1_R7: assert property (@(posedge clk) disable iff (rst)
    credit_ret[0] |-> $past(vc_pop[0]));

  assert_credit_vc2_R7: assert property (@(posedge clk) disable iff (rst)
    credit_ret[1] |-> $past(vc_pop[1]));

  assert_combine_order_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_valid) && combine_mode && $past(combine_mode)) |-> $past(vc_pop[1]));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (vc_count[0] <= CW'(DEPTH)) && (vc_count[1] <= CW'(DEPTH)));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (vc_count[in_vc] < CW'(DEPTH)));
endmodule

bind vc_egress_reassembler vcr_reassembler_chk #(
  .OW(SLOTS*FLIT_W), .CW(CNT_W), .DEPTH(BUF_DEPTH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .combine_mode (combine_mode),
  .in_valid     (in_valid),
  .in_vc        (in_vc),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .credit_ret   (credit_ret),
  .vc_pop       (vc_pop),
  .vc_head_tail (vc_head_tail),
  .vc_count     (vc_count)
);

// File: tb/vc_egress_reassembler_tb.sv
module vc_egress_reassembler_tb;
  localparam int FW = 150;
  localparam int SL = 4;
  localparam int OW = FW*SL;
  localparam int DEPTH = 10;
  localparam int NPK = 20;

  logic clk = 0, rst = 1;
  logic combine_mode = 0, in_valid = 0, in_vc = 0, in_tail = 0, out_ready = 0;
  logic [FW-1:0] in_data = '0;
  logic [1:0] credit_ret;
  logic out_valid;
  logic [OW-1:0] out_data;

  int total = 0, bad = 0;
  int cred [2];
  int credcnt [2];
  int sentcnt [2];
  bit done = 0;
  logic [OW-1:0] rxq [$];
  logic [OW-1:0] exq0 [$];
  logic [OW-1:0] exq1 [$];

  always #5 clk = ~clk;

  vc_egress_reassembler #(.FLIT_W(FW), .SLOTS(SL), .BUF_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .combine_mode(combine_mode), .in_valid(in_valid),
    .in_vc(in_vc), .in_tail(in_tail), .in_data(in_data), .credit_ret(credit_ret),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) rxq.push_back(out_data);
      for (int v = 0; v < 2; v++)
        if (credit_ret[v]) begin cred[v]++; credcnt[v]++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rnd_flit();
    logic [159:0] t;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return t[FW-1:0];
  endfunction

  function automatic logic [OW-1:0] mk_word(input logic [FW-1:0] f [4], input int n, input int base);
    logic [OW-1:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w[(base+i)*FW +: FW] = f[i];
    return w;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_flit(input int v, input bit tl, input logic [FW-1:0] d);
    while (cred[v] == 0) cyc(1);
    in_valid = 1; in_vc = v[0]; in_tail = tl; in_data = d;
    cred[v]--; sentcnt[v]++;
    cyc(1);
    in_valid = 0; in_tail = 0;
  endtask

  task automatic send_pkt(input int v, input logic [FW-1:0] f [4], input int n);
    for (int i = 0; i < n; i++) send_flit(v, i == n-1, f[i]);
  endtask

  function automatic void fill(ref logic [FW-1:0] f [4]);
    for (int i = 0; i < 4; i++) f[i] = rnd_flit();
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa [4], fb [4], fc [4];
    logic [OW-1:0] w1, w2;
    int left [2], pk [2], n [2];
    logic [FW-1:0] cur [2][4];
    void'($urandom(32'd1234));
    cred[0] = DEPTH; cred[1] = DEPTH;
    credcnt[0] = 0; credcnt[1] = 0; sentcnt[0] = 0; sentcnt[1] = 0;
    cyc(3);
    chk(out_valid == 0, "R1 valid in reset", OW'(out_valid), '0);
    chk(credit_ret == 0, "R1 credit in reset", OW'(credit_ret), '0);
    rst = 0;
    cyc(1);
    chk(out_data == '0 && !out_valid, "R1 after reset", out_data, '0);

    // R5 and R4: stalled output, then both channels waiting
    fill(fa); fill(fb); fill(fc);
    send_pkt(0, fa, 2);
    send_pkt(1, fb, 2);
    send_pkt(0, fc, 1);
    cyc(3);
    w1 = out_data;
    cyc(4);
    chk(out_valid == 1, "R4 valid held", OW'(out_valid), OW'(1));
    chk(out_data == w1 && w1 == mk_word(fa, 2, 0), "R4 data held", out_data, mk_word(fa, 2, 0));
    out_ready = 1;
    cyc(10);
    chk(rxq.size() == 3, "R5 word count", OW'(rxq.size()), OW'(3));
    if (rxq.size() == 3) begin
      chk(rxq[0] == mk_word(fa, 2, 0), "R3 first word", rxq[0], mk_word(fa, 2, 0));
      chk(rxq[1] == mk_word(fc, 1, 0), "R5 vc1 priority", rxq[1], mk_word(fc, 1, 0));
      chk(rxq[2] == mk_word(fb, 2, 0), "R2 vc2 word", rxq[2], mk_word(fb, 2, 0));
    end
    rxq.delete();

    // R6: channel-2 packet started, channel-1 arrives mid-packet
    fill(fa); fill(fb);
    send_flit(1, 0, fb[0]);
    cyc(2);
    send_flit(0, 1, fa[0]);
    cyc(2);
    send_flit(1, 1, fb[1]);
    cyc(8);
    chk(rxq.size() == 2, "R6 word count", OW'(rxq.size()), OW'(2));
    if (rxq.size() == 2) begin
      chk(rxq[0] == mk_word(fb, 2, 0), "R6 no preemption", rxq[0], mk_word(fb, 2, 0));
      chk(rxq[1] == mk_word(fa, 1, 0), "R6 vc1 after", rxq[1], mk_word(fa, 1, 0));
    end
    rxq.delete();

    // R3: full four-flit packet
    fill(fa);
    send_pkt(0, fa, 4);
    cyc(6);
    chk(rxq.size() == 1 && rxq[0] == mk_word(fa, 4, 0), "R3 four flits",
        (rxq.size() > 0) ? rxq[0] : '0, mk_word(fa, 4, 0));
    rxq.delete();

    // R8: combine mode
    combine_mode = 1;
    cyc(1);
    fill(fa); fill(fb);
    send_pkt(0, fa, 2);
    cyc(6);
    chk(out_valid == 0 && rxq.size() == 0, "R8 waits for both", OW'(out_valid), '0);
    send_pkt(1, fb, 1);
    cyc(8);
    w2 = mk_word(fa, 2, 2) | mk_word(fb, 1, 0);
    chk(rxq.size() == 1 && rxq[0] == w2, "R8 combined word",
        (rxq.size() > 0) ? rxq[0] : '0, w2);
    rxq.delete();
    combine_mode = 0;
    cyc(2);

    // R2, R7: random interleaved traffic with random stalls
    left[0] = 0; left[1] = 0; pk[0] = 0; pk[1] = 0; n[0] = 0; n[1] = 0;
    while (pk[0] < NPK || pk[1] < NPK || left[0] > 0 || left[1] > 0) begin
      int v;
      bit ok0, ok1;
      out_ready = ($urandom % 4) != 0;
      ok0 = cred[0] > 0 && (left[0] > 0 || pk[0] < NPK);
      ok1 = cred[1] > 0 && (left[1] > 0 || pk[1] < NPK);
      v = $urandom % 2;
      if (v == 0 && !ok0) v = 1;
      if (v == 1 && !ok1) v = ok0 ? 0 : -1;
      if (v >= 0 && ($urandom % 4) != 0) begin
        if (left[v] == 0) begin
          n[v] = 1 + ($urandom % 4);
          for (int i = 0; i < 4; i++) cur[v][i] = rnd_flit();
          left[v] = n[v];
        end
        in_valid = 1; in_vc = v[0]; in_tail = (left[v] == 1);
        in_data = cur[v][n[v] - left[v]];
        cred[v]--; sentcnt[v]++;
        left[v]--;
        if (left[v] == 0) begin
          pk[v]++;
          if (v == 0) exq0.push_back(mk_word(cur[0], n[0], 0));
          else        exq1.push_back(mk_word(cur[1], n[1], 0));
        end
      end
      cyc(1);
      in_valid = 0; in_tail = 0;
    end
    out_ready = 1;
    cyc(100);
    while (rxq.size() > 0) begin
      logic [OW-1:0] w;
      bit hit;
      w = rxq.pop_front();
      hit = 0;
      if (exq0.size() > 0 && w == exq0[0]) begin void'(exq0.pop_front()); hit = 1; end
      else if (exq1.size() > 0 && w == exq1[0]) begin void'(exq1.pop_front()); hit = 1; end
      chk(hit, "R2 random word is whole packet", w, (exq0.size() > 0) ? exq0[0] : '0);
    end
    chk(exq0.size() == 0, "R2 vc1 all delivered", OW'(exq0.size()), '0);
    chk(exq1.size() == 0, "R2 vc2 all delivered", OW'(exq1.size()), '0);
    chk(credcnt[0] == sentcnt[0], "R7 vc1 credits", OW'(credcnt[0]), OW'(sentcnt[0]));
    chk(credcnt[1] == sentcnt[1], "R7 vc2 credits", OW'(credcnt[1]), OW'(sentcnt[1]));
    chk(cred[0] == DEPTH && cred[1] == DEPTH, "R9 credits restored", OW'(cred[0]), OW'(DEPTH));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule